// File: doc/BRIEF.md
# Handshake-Strobed General-Purpose Port

This block is one 8-bit general-purpose I/O port of a microcontroller-side peripheral. A host reaches it through a two-entry register interface: a port data register and a control register. The control register sets the port direction, the output driver style and the interrupt mask. Each port has its own handshake strobe line, which works in both directions.

When the port is an input, a qualifying edge on the strobe line loads the pin values into the data register and marks new data as pending. The pending flag, gated by the mask, pulls on a shared open-drain interrupt line. A host read of the data register clears it. When the port is an output, each host write to the data register drives the pins. The pins keep that value until the next write, and each such write also sends out a strobe pulse of a fixed number of clock cycles. The outputs can act as push-pull drivers or as open-drain drivers. Open-drain behaviour is modelled by switching each pin's output enable.

The port logic runs from the block clock and keeps working whatever the power state of the rest of the device.

Top module: `strobed_port`

## Requirements
- R1: After reset the port is an input with every pin enable low, the strobe enable low, the interrupt request low, and both registers reading zero.
- R2: Writing address 1 loads the control register from write-data bits 2:0: bit 0 is the direction (1 = output), bit 1 is the driver style (1 = open-drain), bit 2 is the interrupt enable. Reading address 1 returns those three bits with all higher bits zero. Address 0 is the data register.
- R3: In output mode with push-pull style, every pin enable is high and the pins show the data register one cycle after the write.
- R4: In output mode with open-drain style, a pin's enable is high exactly when its data bit is 0.
- R5: In output mode, a write to the data register makes the strobe output high for exactly PULSE_CYC cycles, starting the cycle after the write. The strobe enable follows the direction bit.
- R6: A data write during a running pulse restarts it, so the strobe stays high for PULSE_CYC cycles counted from the last write.
- R7: In input mode every pin enable is low. A falling strobe edge (rising when CAPTURE_RISING=1) loads the pin values into the data register. The new value is readable after the third rising clock edge that follows the strobe change. An edge of the other polarity loads nothing.
- R8: A capture sets the pending flag. The interrupt request equals pending AND enable. A host read of address 0 clears pending, but a capture in the same cycle keeps it set. Masking leaves the flag untouched.
- R9: In input mode a host write to address 0 changes neither the data register nor the strobe. In output mode strobe-line edges capture nothing and set no pending flag.
- R10: The data register and the pins keep their value until the next accepted write or capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 1 | Register select: 0 data, 1 control |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe for the selected register |
| host_wdata | input | WIDTH | Host write data |
| host_rdata | output | WIDTH | Read data of the selected register (combinational) |
| pin_in | input | WIDTH | Pad input values |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Per-pin pad output enable |
| stb_in | input | 1 | Strobe pad input value |
| stb_out | output | 1 | Strobe pad output value (active-high pulse) |
| stb_oe | output | 1 | Strobe pad output enable |
| irq_pull | output | 1 | Request to pull the shared open-drain interrupt line |

## Verification
A wrong control or data register shows up at the pin enables and the pin values on the next cycle. Those outputs are compared against a reference model on every clock, so such a fault is caught within one cycle of the bad write or capture. A wrong pulse counter shows up as a strobe pulse that is too long or too short, and the cycle-by-cycle comparison reports it on the first cycle where the pulse differs. A wrong synchroniser stage or a wrong edge polarity leaves the data register without the new value three edges after the strobe moves. A pending flag that fails to set or to clear shows directly on the interrupt request.

// File: rtl/strobed_port_pkg.sv
package strobed_port_pkg;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic irq_en;
    logic od;
    logic dir;
  } port_ctrl_t;

  localparam int CTRL_BITS = 3;

  function automatic logic edge_hit(input logic cur, input logic prev, input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/sp_edge_sync.sv
module sp_edge_sync #(
  parameter bit CAPTURE_RISING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_in,
  output logic edge_o
);
  import strobed_port_pkg::*;

  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= stb_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  generate
    if (CAPTURE_RISING) begin : g_rise
      assign edge_o = edge_hit(sync_q, hist_q, 1'b1);
    end else begin : g_fall
      assign edge_o = edge_hit(sync_q, hist_q, 1'b0);
    end
  endgenerate

endmodule

// File: rtl/sp_pulse_gen.sv
module sp_pulse_gen #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic trig,
  output logic pulse
);
  localparam int CW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSE_CYC);

  logic [CW-1:0] left_q;

  function automatic logic [CW-1:0] next_left(input logic [CW-1:0] cur, input logic go, input logic en);
    if (!en)               return '0;
    else if (go)           return FULL;
    else if (cur != '0)    return cur - 1'b1;
    else                   return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= next_left(left_q, trig, run);
  end

  assign pulse = run && (left_q != '0);

endmodule

// File: rtl/sp_pad_drive.sv
module sp_pad_drive #(
  parameter int WIDTH = 8
) (
  input  logic             dir,
  input  logic             od,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] oe
);
  function automatic logic [WIDTH-1:0] enables(input logic d, input logic o, input logic [WIDTH-1:0] v);
    if (!d)     return '0;
    else if (o) return ~v;
    else        return '1;
  endfunction

  assign oe = enables(dir, od, data);

endmodule

// File: rtl/strobed_port.sv
module strobed_port
  import strobed_port_pkg::*;
#(
  parameter int WIDTH          = 8,
  parameter int PULSE_CYC      = 4,
  parameter bit CAPTURE_RISING = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [WIDTH-1:0] host_wdata,
  output logic [WIDTH-1:0] host_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic             stb_in,
  output logic             stb_out,
  output logic             stb_oe,
  output logic             irq_pull
);

  port_ctrl_t       ctrl_q;
  logic [WIDTH-1:0] data_q;
  logic             pending;

  logic dir_w, od_w, ien_w;
  logic strobe_edge, cap_evt, out_wr_evt, ctrl_wr_evt, rd_clr_evt;

  assign dir_w = ctrl_q.dir;
  assign od_w  = ctrl_q.od;
  assign ien_w = ctrl_q.irq_en;

  assign out_wr_evt  = host_wr && (reg_sel_e'(host_addr) == SEL_DATA) && dir_w;
  assign ctrl_wr_evt = host_wr && (reg_sel_e'(host_addr) == SEL_CTRL);
  assign rd_clr_evt  = host_rd && (reg_sel_e'(host_addr) == SEL_DATA);
  assign cap_evt     = strobe_edge && !dir_w;

  sp_edge_sync #(.CAPTURE_RISING(CAPTURE_RISING)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_in (stb_in),
    .edge_o (strobe_edge)
  );

  sp_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (dir_w),
    .trig  (out_wr_evt),
    .pulse (stb_out)
  );

  sp_pad_drive #(.WIDTH(WIDTH)) u_pad (
    .dir  (dir_w),
    .od   (od_w),
    .data (data_q),
    .oe   (pin_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      data_q  <= '0;
      pending <= 1'b0;
    end else begin
      if (ctrl_wr_evt) ctrl_q <= port_ctrl_t'(host_wdata[CTRL_BITS-1:0]);
      if (out_wr_evt)   data_q <= host_wdata;
      else if (cap_evt) data_q <= pin_in;
      if (cap_evt)         pending <= 1'b1;
      else if (rd_clr_evt) pending <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (reg_sel_e'(host_addr) == SEL_DATA) host_rdata = data_q;
    else                                   host_rdata[CTRL_BITS-1:0] = ctrl_q;
  end

  assign pin_out  = data_q;
  assign stb_oe   = dir_w;
  assign irq_pull = pending && ien_w;

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir,
  input logic             od,
  input logic             ien,
  input logic             pending,
  input logic             cap_evt,
  input logic             out_wr_evt,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] pin_oe,
  input logic             stb_out,
  input logic             stb_oe,
  input logic             irq_pull
);

  // R3
  pushpull_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && !od) |-> (&pin_oe));

  // R4
  opendrain_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && od) |-> ((pin_oe & data_q) == '0));

  // R5
  pulse_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_evt |=> stb_out);

  // R5
  pulse_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_out |-> stb_oe);

  // R7
  input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir |-> (pin_oe == '0));

  // R8
  capture_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> pending);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> (pending && ien));

  // R9
  no_pulse_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir |-> !stb_out);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_wr_evt && !cap_evt) |=> $stable(data_q));

endmodule

bind strobed_port sp_checker #(.WIDTH(WIDTH)) u_sp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .dir        (dir_w),
  .od         (od_w),
  .ien        (ien_w),
  .pending    (pending),
  .cap_evt    (cap_evt),
  .out_wr_evt (out_wr_evt),
  .data_q     (data_q),
  .pin_oe     (pin_oe),
  .stb_out    (stb_out),
  .stb_oe     (stb_oe),
  .irq_pull   (irq_pull)
);

// File: tb/strobed_port_bench.sv
module strobed_port_bench;
  localparam int W = 8;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_addr = 1'b0;
  logic         host_wr = 1'b0;
  logic         host_rd = 1'b0;
  logic [W-1:0] host_wdata = '0;
  logic [W-1:0] host_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         stb_in = 1'b1;
  logic         stb_out, stb_oe, irq_pull;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strobed_port #(.WIDTH(W), .PULSE_CYC(P), .CAPTURE_RISING(1'b0)) u_strobed_port (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .stb_in(stb_in), .stb_out(stb_out), .stb_oe(stb_oe), .irq_pull(irq_pull)
  );

  // behavioural reference model
  int m_dir, m_od, m_en, m_data, m_pend, m_left;
  int stb_hist[$];

  task automatic model_reset();
    m_dir = 0; m_od = 0; m_en = 0; m_data = 0; m_pend = 0; m_left = 0;
    stb_hist = {1, 1, 1};
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int seen_new, seen_old, captured, dwrite;
      seen_new = stb_hist[1];
      seen_old = stb_hist[2];
      captured = (m_dir == 0) && (seen_old == 1) && (seen_new == 0);
      dwrite   = host_wr && (host_addr == 1'b0) && (m_dir == 1);
      if (m_dir == 0)  m_left = 0;
      else if (dwrite) m_left = P;
      else if (m_left > 0) m_left = m_left - 1;
      if (dwrite)        m_data = host_wdata;
      else if (captured) m_data = pin_in;
      if (captured) m_pend = 1;
      else if (host_rd && host_addr == 1'b0) m_pend = 0;
      if (host_wr && host_addr == 1'b1) begin
        m_dir = host_wdata[0]; m_od = host_wdata[1]; m_en = host_wdata[2];
      end
      stb_hist.push_front(int'(stb_in));
      void'(stb_hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, 5 ns after the rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      int exp_oe;
      exp_oe = (m_dir == 0) ? 0 : (m_od ? (~m_data & 8'hFF) : 8'hFF);
      check(int'(pin_oe) == exp_oe, "R3/R4/R7 pin_oe", int'(pin_oe), exp_oe);
      if (m_dir == 1) check(int'(pin_out) == m_data, "R10 pin_out", int'(pin_out), m_data);
      check(int'(stb_out) == (m_left > 0), "R5/R6 stb_out", int'(stb_out), int'(m_left > 0));
      check(int'(stb_oe) == m_dir, "R5 stb_oe", int'(stb_oe), m_dir);
      check(int'(irq_pull) == (m_pend && m_en), "R8 irq_pull", int'(irq_pull), int'(m_pend && m_en));
      if (host_addr == 1'b0) check(int'(host_rdata) == m_data, "R2 rdata data", int'(host_rdata), m_data);
      else check(int'(host_rdata) == (m_dir | (m_od << 1) | (m_en << 2)), "R2 rdata ctrl",
                 int'(host_rdata), m_dir | (m_od << 1) | (m_en << 2));
    end
  end

  task automatic host_write(input logic a, input logic [W-1:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [W-1:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] rd;
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(pin_oe == '0 && !stb_oe && !irq_pull, "R1 reset outputs", int'(pin_oe), 0);
    host_read(1'b0, rd); check(rd == 8'h00, "R1 data reset", int'(rd), 0);
    host_read(1'b1, rd); check(rd == 8'h00, "R1 ctrl reset", int'(rd), 0);

    // R2 control map, upper bits read zero
    host_write(1'b1, 8'hF5);
    host_read(1'b1, rd); check(rd == 8'h05, "R2 ctrl readback", int'(rd), 5);

    // R3 push-pull output and R5 pulse width
    host_write(1'b0, 8'hA5);
    check(pin_out == 8'hA5 && pin_oe == 8'hFF, "R3 push-pull drive", int'(pin_oe), 8'hFF);
    n = 0;
    while (stb_out && n < 50) begin n++; @(negedge clk); end
    check(n == P, "R5 pulse width", n, P);

    // R10 hold
    idle(6);
    check(pin_out == 8'hA5, "R10 output held", int'(pin_out), 8'hA5);

    // R4 open-drain
    host_write(1'b1, 8'h07);
    idle(1);
    check(pin_oe == 8'h5A, "R4 open-drain enables", int'(pin_oe), 8'h5A);

    // R6 retrigger
    host_write(1'b0, 8'h0F);
    idle(1);
    host_write(1'b0, 8'hF0);
    n = 0;
    while (stb_out && n < 50) begin n++; @(negedge clk); end
    check(n == P, "R6 retrigger full width", n, P);
    check(pin_oe == 8'h0F, "R4 open-drain after rewrite", int'(pin_oe), 8'h0F);

    // R9 strobe edges ignored in output mode
    pin_in = 8'h66; stb_in = 1'b0; idle(5); stb_in = 1'b1; idle(5);
    host_read(1'b0, rd); check(rd == 8'hF0, "R9 no capture in output mode", int'(rd), 8'hF0);
    check(!irq_pull, "R9 no pending in output mode", int'(irq_pull), 0);

    // R9 write ignored in input mode
    host_write(1'b1, 8'h04);
    host_write(1'b0, 8'h33);
    check(!stb_out, "R9 no pulse in input mode", int'(stb_out), 0);
    host_read(1'b0, rd); check(rd == 8'hF0, "R9 write ignored in input mode", int'(rd), 8'hF0);

    // R7 falling-edge capture with exact latency
    pin_in = 8'h3C;
    @(negedge clk); stb_in = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    check(host_rdata == 8'hF0, "R7 not yet captured after two edges", int'(host_rdata), 8'hF0);
    @(posedge clk); #2;
    check(host_rdata == 8'h3C, "R7 captured after third edge", int'(host_rdata), 8'h3C);
    @(negedge clk);
    check(irq_pull, "R8 irq after capture", int'(irq_pull), 1);

    // R7 rising edge does not capture
    pin_in = 8'h99; stb_in = 1'b1; idle(5);
    host_read(1'b0, rd); check(rd == 8'h3C, "R7 rising edge ignored", int'(rd), 8'h3C);
    idle(1);
    check(!irq_pull, "R8 read clears pending", int'(irq_pull), 0);

    // R8 mask keeps the flag
    host_write(1'b1, 8'h00);
    pin_in = 8'h5E; stb_in = 1'b0; idle(5); stb_in = 1'b1;
    check(!irq_pull, "R8 masked request", int'(irq_pull), 0);
    host_write(1'b1, 8'h04);
    idle(1);
    check(irq_pull, "R8 pending survives mask", int'(irq_pull), 1);
    host_read(1'b0, rd); check(rd == 8'h5E, "R7 second capture", int'(rd), 8'h5E);
    idle(2);
    check(!irq_pull, "R8 cleared after read", int'(irq_pull), 0);

    // R1 reset again mid-run
    host_write(1'b1, 8'h01);
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    check(pin_oe == '0 && !stb_oe, "R1 reset returns to input", int'(pin_oe), 0);

    idle(4);
    finish_run();
  end

endmodule